// File: doc/BRIEF.md
# Latched Input Port with Read-Cleared Interrupt

This block captures sixteen general-purpose input pins, grouped as two 8-bit ports, and raises an active-low interrupt when any of them moves away from the level seen at the last read of its port. Every pin first passes through a two-flop synchronizer. Each bit can run in one of two modes. In live mode a read returns the pin's current level, and the interrupt source goes away by itself if the pin returns before anyone reads it. In hold mode the first departure from the reference level is captured and kept until the port is read.

Software, or a bus bridge in front of the block, uses a small synchronous register interface. It drives an address with a write or read strobe. Read data appears one cycle after the strobe. Reading an input port returns the mixed live and held view of that port. The same read loads the port's reference levels from the pins, drops that port's held captures, and so clears that port's interrupt sources. A per-bit mask register, which resets to all ones, keeps chosen bits off the interrupt line.

Top module: `gpin_latch_irq`

## Requirements
- R1: After reset the hold-enable registers are 0x00, the mask registers are 0xFF, `irq_no` is 1 and `rdata_o` is 0x00.
- R2: A write takes effect on the next clock. Hold-enable registers sit at 0x44 (port 0) and 0x45 (port 1), and mask registers at 0x4A (port 0) and 0x4B (port 1); reading any of them returns its value. Read data appears on `rdata_o` in the cycle after `rd_i` and is held while `rd_i` is low. An unmapped address reads 0x00.
- R3: In live mode (hold-enable bit 0), a read of the port (0x00 for pins 7..0, 0x01 for pins 15..8, bit n of the port being pin 8*port+n) returns the synchronized pin level. The bit is an interrupt source while that level differs from the level at the last read of the port, and it stops being one by itself when the pin returns.
- R4: In hold mode (hold-enable bit 1), the first change away from the reference is captured. A read returns the captured value even if the pin has since moved back. The following read returns the live level.
- R5: Reading one input port clears the held captures and interrupt sources of that port only. Sources in the other port stay pending.
- R6: If a live bit and a held bit change together and the live bit then returns, the interrupt stays asserted. The read then shows only the held bit's change and clears the interrupt.
- R7: Switching a bit from hold mode to live mode does not clear its pending capture or the interrupt. The next read returns the pin's live level.
- R8: After a bit is switched from live mode to hold mode while its pin differs from the reference, a read returns the captured level, not the pin's current level.
- R9: `irq_no` is low exactly when some interrupt source whose mask bit is 0 was set in the previous cycle. Masked sources never pull it low.
- R10: A pin change reaches the interrupt output no sooner than three clock edges after it appears: two synchronizer flops plus the interrupt register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 16 | Asynchronous input pins; bits 7..0 form port 0 |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after `rd_i` |
| irq_no | output | 1 | Interrupt, active low |

## Verification
On every cycle, the assertions check the following. Read data only moves after a read strobe. A configuration write is visible on the next edge. Held captures survive every cycle without a read of their port, including cycles that change the mode. A port read empties that port's captures. A fully masked port pair keeps the interrupt high. Only the directed scenarios can show the values a read returns in the mixed, mode-switch and pin-returns cases, the exact three-edge latency from pin to interrupt, and the self-clearing of a live source.

// File: rtl/gpin_pkg.sv
package gpin_pkg;
  localparam int unsigned ADDR_W    = 8;
  localparam logic [7:0]  IN_BASE   = 8'h00;
  localparam logic [7:0]  LE_BASE   = 8'h44;
  localparam logic [7:0]  MASK_BASE = 8'h4A;
endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpin_port.sv
module gpin_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] hold_en_i,
  input  logic         clr_i,
  output logic [W-1:0] rd_val_o,
  output logic [W-1:0] src_o,
  output logic [W-1:0] held_o
);
  logic [W-1:0] ref_q, held_q, hval_q, cap, use_hold;

  // capture only the first departure from the reference
  assign cap      = hold_en_i & ~held_q & (lvl_i ^ ref_q);
  assign use_hold = hold_en_i & held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      held_q <= '0;
      hval_q <= '0;
    end else begin
      hval_q <= (hval_q & ~cap) | (lvl_i & cap);
      if (clr_i) begin
        ref_q  <= lvl_i;
        held_q <= '0;
      end else begin
        held_q <= held_q | cap;
      end
    end
  end

  assign rd_val_o = (use_hold & hval_q) | (~use_hold & lvl_i);
  // a capture stays pending across a switch back to live mode
  assign src_o    = held_q | (~hold_en_i & (lvl_i ^ ref_q));
  assign held_o   = held_q;
endmodule

// File: rtl/gpin_latch_irq.sv
module gpin_latch_irq
  import gpin_pkg::*;
#(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [PORT_W*NUM_PORTS-1:0]   pins_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          wr_i,
  input  logic                          rd_i,
  input  logic [PORT_W-1:0]             wdata_i,
  output logic [PORT_W-1:0]             rdata_o,
  output logic                          irq_no
);
  localparam int unsigned NB = PORT_W * NUM_PORTS;

  logic [NB-1:0]     lvl_s, src_all, held_all, le_flat, mask_flat, rd_all;
  logic [NUM_PORTS-1:0][PORT_W-1:0] le_q, mask_q;
  logic [NUM_PORTS-1:0] clr;
  logic [PORT_W-1:0] rd_next, rdata_q;
  logic              irq_q;

  gpin_sync #(.W(NB)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (lvl_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] A_IN   = IN_BASE + ADDR_W'(p);
    localparam logic [ADDR_W-1:0] A_LE   = LE_BASE + ADDR_W'(p);
    localparam logic [ADDR_W-1:0] A_MASK = MASK_BASE + ADDR_W'(p);

    assign clr[p] = rd_i && (addr_i == A_IN);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        le_q[p]   <= '0;
        mask_q[p] <= '1;
      end else if (wr_i) begin
        if (addr_i == A_LE)   le_q[p]   <= wdata_i;
        if (addr_i == A_MASK) mask_q[p] <= wdata_i;
      end
    end

    assign le_flat[p*PORT_W +: PORT_W]   = le_q[p];
    assign mask_flat[p*PORT_W +: PORT_W] = mask_q[p];

    gpin_port #(.W(PORT_W)) u_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lvl_i    (lvl_s[p*PORT_W +: PORT_W]),
      .hold_en_i(le_q[p]),
      .clr_i    (clr[p]),
      .rd_val_o (rd_all[p*PORT_W +: PORT_W]),
      .src_o    (src_all[p*PORT_W +: PORT_W]),
      .held_o   (held_all[p*PORT_W +: PORT_W])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr_i == IN_BASE + ADDR_W'(p))   rd_next = rd_all[p*PORT_W +: PORT_W];
      if (addr_i == LE_BASE + ADDR_W'(p))   rd_next = le_q[p];
      if (addr_i == MASK_BASE + ADDR_W'(p)) rd_next = mask_q[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_next;
      irq_q <= |(src_all & ~mask_flat);
    end
  end

  assign rdata_o = rdata_q;
  assign irq_no  = ~irq_q;
endmodule

// File: rtl/gpin_latch_irq_chk.sv
module gpin_latch_irq_chk
  import gpin_pkg::*;
#(
  parameter int unsigned PORT_W    = 8,
  parameter int unsigned NUM_PORTS = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rd_i,
  input logic                        wr_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [PORT_W-1:0]           wdata_i,
  input logic [PORT_W-1:0]           rdata_o,
  input logic                        irq_no,
  input logic [PORT_W*NUM_PORTS-1:0] le_i,
  input logic [PORT_W*NUM_PORTS-1:0] mask_i,
  input logic [PORT_W*NUM_PORTS-1:0] held_i
);
  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_all_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |=> irq_no);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_IN = IN_BASE + ADDR_W'(p);
    localparam logic [ADDR_W-1:0] A_LE = LE_BASE + ADDR_W'(p);

    assert_le_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == A_LE) |=> (le_i[p*PORT_W +: PORT_W] == $past(wdata_i)));

    // R4 / R7: captures persist until their own port is read
    assert_held_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_i && addr_i == A_IN) |=>
        ((held_i[p*PORT_W +: PORT_W] & $past(held_i[p*PORT_W +: PORT_W]))
          == $past(held_i[p*PORT_W +: PORT_W])));

    assert_read_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == A_IN) |=> (held_i[p*PORT_W +: PORT_W] == '0));
  end
endmodule

bind gpin_latch_irq gpin_latch_irq_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .irq_no (irq_no),
  .le_i   (le_flat),
  .mask_i (mask_flat),
  .held_i (held_all)
);

// File: tb/gpin_latch_irq_tb.sv
`timescale 1ns/1ps
module gpin_latch_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpin_latch_irq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk); pins = v;
    wait_cyc(5);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'b0, irq_n}, 8'h01);
    reg_rd(8'h44, d); chk("R1 le0", d, 8'h00);
    reg_rd(8'h4B, d); chk("R1 mask1", d, 8'hFF);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    reg_wr(8'h4A, 8'h00); reg_wr(8'h4B, 8'h00);
    reg_rd(8'h4A, d); chk("R2 mask0", d, 8'h00);
    reg_wr(8'h45, 8'hA5);
    reg_rd(8'h45, d); chk("R2 le1", d, 8'hA5);
    wait_cyc(2); chk("R2 rdata held", rdata, 8'hA5);
    reg_wr(8'h45, 8'h00);
    reg_rd(8'h20, d); chk("R2 unmapped", d, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] d;
    @(negedge clk); pins = 16'h0010;
    wait_cyc(2); chk("R10 two edges", {7'b0, irq_n}, 8'h01);
    wait_cyc(1); chk("R10 third edge", {7'b0, irq_n}, 8'h00);
    set_pins(16'h0000); chk("R3 self clear", {7'b0, irq_n}, 8'h01);
    set_pins(16'h0010); chk("R3 irq", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R3 live read", d, 8'h10);
    wait_cyc(2); chk("R3 read clears", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    reg_wr(8'h44, 8'h10);
    set_pins(16'h0000); set_pins(16'h0010);
    chk("R4 irq held", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R4 held value", d, 8'h00);
    reg_rd(8'h00, d); chk("R4 next live", d, 8'h10);
    wait_cyc(2); chk("R4 irq cleared", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_isolate();
    logic [7:0] d;
    set_pins(16'h0100);
    reg_rd(8'h01, d); chk("R5 port1 read", d, 8'h01);
    wait_cyc(2); chk("R5 port0 still pending", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R5 port0 held", d, 8'h00);
    wait_cyc(2); chk("R5 all clear", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_mixed();
    logic [7:0] d;
    set_pins(16'h0130); set_pins(16'h0110);
    chk("R6 irq stays", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R6 read", d, 8'h10);
    wait_cyc(2); chk("R6 cleared", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_to_live();
    logic [7:0] d;
    set_pins(16'h0100); set_pins(16'h0110);
    reg_wr(8'h44, 8'h00); wait_cyc(3);
    chk("R7 pending kept", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R7 live read", d, 8'h10);
    wait_cyc(2); chk("R7 cleared", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_to_hold();
    logic [7:0] d;
    set_pins(16'h0100);
    reg_wr(8'h44, 8'h10); wait_cyc(3);
    set_pins(16'h0110);
    reg_rd(8'h00, d); chk("R8 latched level", d, 8'h00);
    wait_cyc(2); chk("R8 cleared", {7'b0, irq_n}, 8'h01);
    reg_wr(8'h44, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    reg_wr(8'h4A, 8'h10);
    set_pins(16'h0100); chk("R9 masked", {7'b0, irq_n}, 8'h01);
    reg_wr(8'h4A, 8'h00); wait_cyc(1);
    chk("R9 unmasked", {7'b0, irq_n}, 8'h00);
    reg_rd(8'h00, d); chk("R9 read", d, 8'h00);
  endtask

  initial begin
    wait_cyc(3); rst_n = 1'b1; wait_cyc(2);
    t_reset(); t_regs(); t_live(); t_hold(); t_isolate();
    t_mixed(); t_to_live(); t_to_hold(); t_mask();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule